// File: doc/BRIEF.md
# Threshold-Triggered Bus-Master Drain Controller

This block buffers a continuous stream of sample words and moves them into system memory as a bus master. Samples are written into an internal buffer every cycle they are offered, whatever the block is doing on the bus side. When the buffer holds half of its capacity, the block asks a bus arbiter for mastership. It keeps asking until the grant arrives. Once granted, it writes buffered words to consecutive memory addresses in back-to-back cycles. It stops only when the buffer is empty, which includes any words that piled up during the grant wait or during the burst.

A descriptor unit next to the block supplies a start address and a word budget. Each write beat moves the address forward by one word and uses up one unit of the budget. When the budget runs out in the middle of a burst, the block keeps the bus and holds off. It waits until the descriptor unit loads a fresh address and budget, then continues. After the buffer is empty, the block lets go of the bus for at least one cycle. It then waits until the threshold is reached again.

Top module: `burst_drain_ctrl`

## Requirements
- R1: After reset, arb_req, bus_busy, wr_valid, ovf_flag and desc_wait are all low.
- R2: arb_req is raised only once the buffer holds at least DEPTH/2 words. With fewer words buffered and the block idle, arb_req stays low.
- R3: Before arb_gnt is seen, no write beat is offered (wr_valid low) and bus_busy stays low. Samples offered during the wait are still accepted, so occupancy can exceed DEPTH/2.
- R4: After the grant, bus_busy is high, and words appear on wr_data in the exact order they were accepted, one per cycle while wr_ready is high.
- R5: A burst ends only when the buffer is empty and the last beat has been accepted. Words that arrive during the wait or the burst are part of it. At the end, arb_req and bus_busy drop on the same edge and both stay low for at least one cycle.
- R6: Each beat's wr_addr equals the descriptor base plus the number of beats issued since that descriptor was loaded (word addressing, +1 per beat).
- R7: While wr_valid is high and wr_ready is low, wr_data and wr_addr hold their values and wr_valid stays high. No word is lost or duplicated.
- R8: When the word budget from the descriptor reaches zero during a burst, desc_wait goes high, no further beat is issued, and bus_busy stays high. A pulse on desc_load, which loads desc_base and desc_count, resumes the burst from the new base.
- R9: A sample offered while the buffer holds DEPTH words is discarded and sets ovf_flag. ovf_flag stays high until reset.
- R10: After a release, the block serves the next threshold crossing with a new request/grant/burst cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new sample is offered this cycle |
| smp_data | input | DATA_W | Sample word |
| ovf_flag | output | 1 | Sticky: a sample was discarded because the buffer was full |
| arb_req | output | 1 | Bus mastership request to the arbiter |
| arb_gnt | input | 1 | Grant from the arbiter |
| bus_busy | output | 1 | Block currently owns the bus |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | ADDR_W | Word address of the beat |
| wr_data | output | DATA_W | Data of the beat |
| desc_load | input | 1 | Load a new base address and word budget |
| desc_base | input | ADDR_W | Base word address |
| desc_count | input | CNT_W | Word budget |
| desc_wait | output | 1 | Burst paused because the budget is spent |

## Verification
On every cycle, the bound checker enforces the bus-side rules: beats only while bus_busy is high, bus_busy only together with arb_req, and a request that rises only from a half-full buffer. It also checks that a stalled beat holds its data and address, that a release leaves the bus idle for a cycle, that the overflow flag never clears on its own, and that the budget pause only happens while the bus is held. Other properties need a history that only the bench's scenarios supply. These are the exact ordering and addressing of every word across several bursts, the draining of words that arrived during a long grant wait, the resumption at a new base after the budget runs out, and the absence of discarded samples from memory.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2,
    ST_REL   = 2'd3
  } drain_state_t;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              ovf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic full, push_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;

  // storage with registered read: block RAM friendly, no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
    if (pop)     pop_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + LW'(push_ok) - LW'(pop);
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/beat_tracker.sv
module beat_tracker #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  logic              step,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              exhausted
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  assign exhausted = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      cnt_q     <= '0;
      beat_addr <= '0;
    end else if (load) begin
      addr_q <= base;
      cnt_q  <= count;
    end else if (step) begin
      beat_addr <= addr_q;
      addr_q    <= addr_q + 1'b1;
      cnt_q     <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/drain_fsm.sv
module drain_fsm
  import burst_pkg::*;
#(
  parameter int LW   = 5,
  parameter int HALF = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic          empty,
  input  logic          exhausted,
  input  logic          arb_gnt,
  input  logic          wr_ready,
  output logic          arb_req,
  output logic          bus_busy,
  output logic          wr_valid,
  output logic          pop,
  output logic          desc_wait
);
  drain_state_t state, nxt;
  logic slot_free, drained;

  assign slot_free = !wr_valid || wr_ready;
  assign pop       = (state == ST_BURST) && !empty && !exhausted && slot_free;
  assign drained   = empty && slot_free;
  assign desc_wait = (state == ST_BURST) && exhausted;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (level >= LW'(HALF)) nxt = ST_REQ;
      ST_REQ:   if (arb_gnt)            nxt = ST_BURST;
      ST_BURST: if (drained)            nxt = ST_REL;
      ST_REL:                           nxt = ST_IDLE;
      default:                          nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      arb_req  <= 1'b0;
      bus_busy <= 1'b0;
      wr_valid <= 1'b0;
    end else begin
      state    <= nxt;
      arb_req  <= (nxt == ST_REQ) || (nxt == ST_BURST);
      bus_busy <= (nxt == ST_BURST);
      if (pop)           wr_valid <= 1'b1;
      else if (wr_ready) wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_drain_ctrl.sv
module burst_drain_ctrl #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              ovf_flag,
  output logic              arb_req,
  input  logic              arb_gnt,
  output logic              bus_busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              desc_load,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [CNT_W-1:0]  desc_count,
  output logic              desc_wait
);
  localparam int LW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic [LW-1:0] fifo_level;
  logic fifo_empty, pop, exhausted;

  sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(smp_valid), .push_data(smp_data),
    .pop(pop), .pop_data(wr_data),
    .level(fifo_level), .empty(fifo_empty), .ovf(ovf_flag)
  );

  beat_tracker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst),
    .load(desc_load), .base(desc_base), .count(desc_count),
    .step(pop), .beat_addr(wr_addr), .exhausted(exhausted)
  );

  drain_fsm #(.LW(LW), .HALF(HALF)) u_fsm (
    .clk(clk), .rst(rst),
    .level(fifo_level), .empty(fifo_empty), .exhausted(exhausted),
    .arb_gnt(arb_gnt), .wr_ready(wr_ready),
    .arb_req(arb_req), .bus_busy(bus_busy), .wr_valid(wr_valid),
    .pop(pop), .desc_wait(desc_wait)
  );
endmodule

// File: rtl/burst_drain_ctrl_chk.sv
module burst_drain_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 24,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              arb_req,
  input logic              arb_gnt,
  input logic              bus_busy,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              ovf_flag,
  input logic              desc_wait,
  input logic [LW-1:0]     fifo_level
);
  localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

  // R2
  req_needs_half_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_req) |-> ($past(fifo_level) >= HALF_L));

  // R3
  beat_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> bus_busy);

  // R4
  busy_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_busy |-> arb_req);

  // R5
  release_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> (!arb_req ##1 !arb_req));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  // R8
  pause_holds_bus_chk: assert property (@(posedge clk) disable iff (rst)
    desc_wait |-> bus_busy);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH));
endmodule

bind burst_drain_ctrl burst_drain_ctrl_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .arb_req(arb_req), .arb_gnt(arb_gnt),
  .bus_busy(bus_busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .ovf_flag(ovf_flag),
  .desc_wait(desc_wait), .fifo_level(fifo_level)
);

// File: tb/tb_burst_drain_ctrl.sv
module tb_burst_drain_ctrl;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;
  localparam int HALF   = DEPTH / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [DATA_W-1:0] smp_data = '0;
  logic ovf_flag, arb_req, bus_busy, wr_valid, desc_wait;
  logic arb_gnt = 1'b0;
  logic wr_ready = 1'b1;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic desc_load = 1'b0;
  logic [ADDR_W-1:0] desc_base = '0;
  logic [CNT_W-1:0] desc_count = '0;

  always #2 clk = ~clk;

  burst_drain_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .ovf_flag(ovf_flag), .arb_req(arb_req), .arb_gnt(arb_gnt), .bus_busy(bus_busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .desc_load(desc_load), .desc_base(desc_base), .desc_count(desc_count),
    .desc_wait(desc_wait)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [ADDR_W-1:0] exp_addr = '0;
  int beats = 0;
  int bursts = 0;
  int seq = 1;
  int gnt_lat = 4;
  bit gnt_block = 0;
  bit bp_mode = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_desc(input logic [ADDR_W-1:0] b, input logic [CNT_W-1:0] c);
    step();
    desc_load = 1'b1; desc_base = b; desc_count = c;
    exp_addr = b;
    step();
    desc_load = 1'b0;
  endtask

  // driver: pushes each sample it expects to see written into the scoreboard
  task automatic push_words(input int n, input int gap, input bit keep);
    for (int i = 0; i < n; i++) begin
      step();
      smp_valid = 1'b1;
      smp_data  = DATA_W'(seq);
      if (keep) exp_q.push_back(DATA_W'(seq));
      seq++;
      for (int g = 0; g < gap; g++) begin
        step();
        smp_valid = 1'b0;
      end
    end
    step();
    smp_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while ((arb_req || bus_busy || exp_q.size() != 0) && t < 3000) begin
      step();
      t++;
    end
    repeat (3) step();
    chk(t < 3000, req, "drain completes", t, 0);
  endtask

  // arbiter model with programmable grant latency
  initial begin
    forever begin
      step();
      if (arb_req && !arb_gnt && !gnt_block) begin
        repeat (gnt_lat) step();
        arb_gnt = 1'b1;
      end else if (!arb_req) begin
        arb_gnt = 1'b0;
      end
    end
  end

  // memory-side ready generator
  initial begin
    forever begin
      step();
      cyc++;
      wr_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic pv = 1'b0, pr = 1'b1, pb = 1'b0;
    logic [DATA_W-1:0] pd = '0;
    logic [ADDR_W-1:0] pa = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (bus_busy && !pb) bursts++;
        if (pv && !pr) begin
          // R7: stalled beat holds
          chk(wr_valid && wr_data == pd && wr_addr == pa, "R7", "stalled beat held",
              {wr_data, wr_addr}, {pd, pa});
        end
        if (wr_valid && wr_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected beat data", wr_data, 0);
          end else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            chk(wr_data == e, "R4", "beat data order", wr_data, e);
            chk(wr_addr == exp_addr, "R6", "beat address", wr_addr, exp_addr);
          end
          exp_addr = exp_addr + 1'b1;
          beats++;
        end
      end
      pv = wr_valid; pr = wr_ready; pd = wr_data; pa = wr_addr; pb = bus_busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int b0, n0;
    // R1: reset state
    repeat (4) step();
    chk({arb_req, bus_busy, wr_valid, ovf_flag, desc_wait} == 5'b0, "R1",
        "outputs in reset", {arb_req, bus_busy, wr_valid, ovf_flag, desc_wait}, 0);
    rst = 1'b0;
    step();
    chk({arb_req, bus_busy, wr_valid, ovf_flag, desc_wait} == 5'b0, "R1",
        "outputs after reset", {arb_req, bus_busy, wr_valid, ovf_flag, desc_wait}, 0);
    load_desc(24'h001000, 16'd1000);

    // R2: below threshold no request, at threshold a request
    gnt_lat = 14;
    push_words(HALF - 1, 0, 1);
    repeat (5) step();
    chk(arb_req == 1'b0, "R2", "no request below half", arb_req, 0);
    push_words(1, 0, 1);
    repeat (3) step();
    chk(arb_req == 1'b1, "R2", "request at half", arb_req, 1);
    // R3: no data before grant, more samples still accepted
    push_words(4, 0, 1);
    chk(wr_valid == 1'b0 && bus_busy == 1'b0, "R3", "no beat before grant",
        {wr_valid, bus_busy}, 0);
    chk(beats == 0, "R3", "beats before grant", beats, 0);
    wait_done("R5");
    chk(beats == HALF + 4, "R5", "whole backlog drained", beats, HALF + 4);
    chk(arb_req == 1'b0 && bus_busy == 1'b0, "R5", "bus released",
        {arb_req, bus_busy}, 0);

    // R10 / R4: continuous sampling across several bursts
    gnt_lat = 3;
    b0 = bursts; n0 = beats;
    push_words(40, 1, 1);
    wait_done("R10");
    chk(beats - n0 == 40, "R4", "all words written", beats - n0, 40);
    chk(bursts - b0 >= 2, "R10", "repeated burst cycles", bursts - b0, 2);

    // R7: backpressure
    bp_mode = 1;
    n0 = beats;
    push_words(30, 1, 1);
    wait_done("R7");
    chk(beats - n0 == 30, "R7", "no loss under backpressure", beats - n0, 30);
    bp_mode = 0;

    // R8: budget exhaustion pause and resume
    load_desc(24'h002000, 16'd4);
    gnt_lat = 2;
    n0 = beats;
    push_words(10, 0, 1);
    for (int t = 0; t < 100 && !desc_wait; t++) step();
    repeat (5) step();
    chk(desc_wait == 1'b1 && bus_busy == 1'b1, "R8", "paused with bus held",
        {desc_wait, bus_busy}, 2'b11);
    chk(beats - n0 == 4, "R8", "beats within budget", beats - n0, 4);
    repeat (5) step();
    chk(beats - n0 == 4 && wr_valid == 1'b0, "R8", "no beats while paused",
        beats - n0, 4);
    load_desc(24'h003000, 16'd100);
    wait_done("R8");
    chk(beats - n0 == 10, "R8", "resumed at new base", beats - n0, 10);

    // R9: overflow drops samples, flag sticks
    chk(ovf_flag == 1'b0, "R9", "no overflow yet", ovf_flag, 0);
    gnt_block = 1;
    n0 = beats;
    push_words(DEPTH, 0, 1);
    push_words(3, 0, 0);
    repeat (2) step();
    chk(ovf_flag == 1'b1, "R9", "overflow flagged", ovf_flag, 1);
    gnt_block = 0;
    wait_done("R9");
    chk(beats - n0 == DEPTH, "R9", "dropped words not written", beats - n0, DEPTH);
    chk(ovf_flag == 1'b1, "R9", "overflow sticky", ovf_flag, 1);
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    step();
    chk(ovf_flag == 1'b0, "R1", "overflow cleared by reset", ovf_flag, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule